// File: doc/BRIEF.md
# Register-mapped NAND flash bus bridge

This block turns single-word accesses on a simple synchronous register bus into raw cycles on an 8-bit NAND flash bus. Every write carries a small opcode in its top bits. Depending on that opcode, the write produces one of three things:

- a command-latch cycle,
- an address-latch cycle,
- a data-write cycle.

The byte to send travels in the same word. One opcode produces no bus cycle. Instead it arms a streaming mode, and in that mode every register read fetches one fresh byte from the device with a read-enable pulse. A 16-bit device word is therefore read as two back-to-back byte reads.

The same word reports the device's ready/busy state on every read. The ready/busy pin passes through a flop synchroniser before it is used. The bridge drops `reg_ready` while a bus cycle is in progress, and it ignores strobes that arrive during that time. Setup, strobe-pulse and hold lengths are parameters given in clock cycles.

Top module: `nandbus_bridge`

## Requirements
- R1: After reset `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale` and `nand_io_oe` are 0, `reg_ready` is 1, and streaming mode is off.
- R2: A write whose bits 30:28 equal 0 produces a command-latch cycle. During it `nand_cle` is 1, `nand_ale` is 0 and `nand_io_out` carries bits 23:16 of the written word.
- R3: A write whose bits 30:28 equal 1 produces an address-latch cycle. During it `nand_ale` is 1, `nand_cle` is 0 and `nand_io_out` carries bits 23:16. `nand_cle` and `nand_ale` are never both 1.
- R4: A write whose bits 30:28 equal 3 produces a data-write cycle. During it both latch lines are 0 and `nand_io_out` carries bits 23:16.
- R5: Each write-type cycle has three phases in this order: SETUP_CLKS clocks with `nand_we_n` high, then PULSE_CLKS clocks with it low, then HOLD_CLKS clocks high. The latch lines, `nand_io_out` and `nand_io_oe`=1 stay steady through all three phases, and `reg_ready` is 0 for exactly SETUP_CLKS+PULSE_CLKS+HOLD_CLKS clocks.
- R6: Bit 31 of a write with opcode 0, 1, 2 or 3 sets chip enable. A 1 drives `nand_ce_n` to 0 for that write's cycle, and the setting holds until the next such write.
- R7: A write with opcode 2 starts no bus cycle and enters streaming mode. Each later read then produces exactly one `nand_re_n` low pulse of PULSE_CLKS clocks. It returns the byte present on `nand_io_in` at the last low clock in `reg_rdata[23:16]`, so N reads return N successive device bytes. `reg_ready` is 0 for PULSE_CLKS+HOLD_CLKS clocks.
- R8: `reg_rdata[15]` is 1 when the synchronised `nand_rb_n` is 0 (busy) and 0 when it is 1 (ready), for every read.
- R9: A read outside streaming mode produces no `nand_re_n` pulse and keeps `reg_ready` at 1. On the next clock it returns a word whose only possibly set bit is bit 15.
- R10: Any write whose opcode is not 2 leaves streaming mode.
- R11: Writes with opcodes 4 to 7 produce no bus cycle and leave `nand_ce_n` unchanged.
- R12: `nand_io_oe` is 1 only during write-type cycles. It is 0 while idle and throughout read pulses.
- R13: Strobes that arrive while `reg_ready` is 0 are ignored and change neither the cycle in progress nor the byte it drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, taken when `reg_ready` is 1 |
| reg_rd | input | 1 | Register read strobe, taken when `reg_ready` is 1 |
| reg_wdata | input | 32 | Written word: bit 31 chip enable, 30:28 opcode, 23:16 byte |
| reg_rdata | output | 32 | Read word: 23:16 device byte, 15 busy |
| reg_ready | output | 1 | High when the bridge can take a strobe |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven to the flash I/O bus |
| nand_io_oe | output | 1 | Output enable for `nand_io_out` |
| nand_io_in | input | 8 | Byte sampled from the flash I/O bus |
| nand_rb_n | input | 1 | Ready/busy from the device, low when busy |

## Verification
The bench builds the bridge with SETUP_CLKS=2, PULSE_CLKS=3 and HOLD_CLKS=1. Because the three phases have different lengths, a swapped or miscounted phase shows up in the measured widths, and the hold phase sits at its one-clock minimum. With these short cycles the bench can afford a sweep over all eight opcodes × four bytes × both chip-enable values. A counter-based device model feeds a distinct byte to every read pulse, so a missed or doubled pulse shows up as a wrong byte.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

    // Field positions inside the 32-bit register word (behavioural contract).
    localparam int CE_BIT   = 31;
    localparam int OP_LSB   = 28;
    localparam int DAT_LSB  = 16;
    localparam int BUSY_BIT = 15;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WPULSE,
        PH_WHOLD,
        PH_RPULSE,
        PH_RHOLD
    } phase_e;

    typedef enum logic [2:0] {
        K_IGNORE,
        K_CMD,
        K_ADDR,
        K_DATA,
        K_STREAM
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic       ce;
        logic [7:0] val;
    } req_t;

    function automatic kind_e op_to_kind(input logic [2:0] op);
        case (op)
            3'd0:    return K_CMD;
            3'd1:    return K_ADDR;
            3'd2:    return K_STREAM;
            3'd3:    return K_DATA;
            default: return K_IGNORE;
        endcase
    endfunction

    function automatic logic [31:0] pack_read(input logic busy, input logic [7:0] val);
        logic [31:0] r;
        r = '0;
        r[DAT_LSB +: 8] = val;
        r[BUSY_BIT]     = busy;
        return r;
    endfunction

endpackage

// File: rtl/nbb_sync.sv
module nbb_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q[i] <= RESET_VAL;
                else        ff_q[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q[i] <= RESET_VAL;
                else        ff_q[i] <= ff_q[i-1];
            end
        end
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/nbb_decode.sv
module nbb_decode
    import nbb_pkg::*;
(
    input  logic [31:0] word,
    output req_t        req
);
    logic unused_fields;

    always_comb begin
        req.kind = op_to_kind(word[OP_LSB +: 3]);
        req.ce   = word[CE_BIT];
        req.val  = word[DAT_LSB +: 8];
    end

    // Bits outside opcode, enable and byte carry no meaning on writes.
    assign unused_fields = ^{word[27:24], word[15:0]};
endmodule

// File: rtl/nandbus_bridge.sv
module nandbus_bridge
    import nbb_pkg::*;
#(
    parameter int SETUP_CLKS  = 1,
    parameter int PULSE_CLKS  = 2,
    parameter int HOLD_CLKS   = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_ready,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_io_out,
    output logic        nand_io_oe,
    input  logic [7:0]  nand_io_in,
    input  logic        nand_rb_n
);
    localparam int MAX_A = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
    localparam int MAX_C = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
    localparam int CW    = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CLKS - 1);
    localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CLKS - 1);
    localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CLKS - 1);

    typedef struct packed {
        phase_e      ph;
        logic [CW-1:0] cnt;
        logic        stream;
        logic        ce;
        logic        cle;
        logic        ale;
        logic        oe;
        logic        we_n;
        logic        re_n;
        logic [7:0]  dout;
        logic [31:0] rdata;
    } st_t;

    localparam st_t ST_RESET = '{
        ph:     PH_IDLE,
        cnt:    '0,
        stream: 1'b0,
        ce:     1'b0,
        cle:    1'b0,
        ale:    1'b0,
        oe:     1'b0,
        we_n:   1'b1,
        re_n:   1'b1,
        dout:   8'h00,
        rdata:  32'h0
    };

    st_t  st_d, st_q;
    req_t req;
    logic rb_sync;
    logic busy;
    logic cnt_done;

    nbb_decode u_decode (
        .word (reg_wdata),
        .req  (req)
    );

    nbb_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_rb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nand_rb_n),
        .q     (rb_sync)
    );

    assign busy     = ~rb_sync;
    assign cnt_done = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (reg_wr) begin
                    case (req.kind)
                        K_CMD, K_ADDR, K_DATA: begin
                            st_d.ph     = PH_WSETUP;
                            st_d.cnt    = SETUP_LD;
                            st_d.stream = 1'b0;
                            st_d.ce     = req.ce;
                            st_d.cle    = (req.kind == K_CMD);
                            st_d.ale    = (req.kind == K_ADDR);
                            st_d.oe     = 1'b1;
                            st_d.dout   = req.val;
                        end
                        K_STREAM: begin
                            st_d.stream = 1'b1;
                            st_d.ce     = req.ce;
                        end
                        default: begin
                            st_d.stream = 1'b0;
                        end
                    endcase
                end else if (reg_rd) begin
                    if (st_q.stream) begin
                        st_d.ph   = PH_RPULSE;
                        st_d.cnt  = PULSE_LD;
                        st_d.re_n = 1'b0;
                    end else begin
                        st_d.rdata = pack_read(busy, 8'h00);
                    end
                end
            end
            PH_WSETUP: begin
                if (cnt_done) begin
                    st_d.ph   = PH_WPULSE;
                    st_d.cnt  = PULSE_LD;
                    st_d.we_n = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            PH_WPULSE: begin
                if (cnt_done) begin
                    st_d.ph   = PH_WHOLD;
                    st_d.cnt  = HOLD_LD;
                    st_d.we_n = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            PH_WHOLD: begin
                if (cnt_done) begin
                    st_d.ph   = PH_IDLE;
                    st_d.cle  = 1'b0;
                    st_d.ale  = 1'b0;
                    st_d.oe   = 1'b0;
                    st_d.dout = 8'h00;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            PH_RPULSE: begin
                if (cnt_done) begin
                    st_d.ph    = PH_RHOLD;
                    st_d.cnt   = HOLD_LD;
                    st_d.re_n  = 1'b1;
                    st_d.rdata = pack_read(busy, nand_io_in);
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            PH_RHOLD: begin
                if (cnt_done) begin
                    st_d.ph = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            default: st_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign reg_ready   = (st_q.ph == PH_IDLE);
    assign reg_rdata   = st_q.rdata;
    assign nand_ce_n   = ~st_q.ce;
    assign nand_cle    = st_q.cle;
    assign nand_ale    = st_q.ale;
    assign nand_we_n   = st_q.we_n;
    assign nand_re_n   = st_q.re_n;
    assign nand_io_out = st_q.dout;
    assign nand_io_oe  = st_q.oe;
endmodule

// File: rtl/nbb_checker.sv
module nbb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_ready,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic [7:0] nand_io_out,
    input logic       nand_io_oe
);
    a_r3_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    a_r5_we_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_io_oe);

    a_r5_latch_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_io_out)));

    a_r5_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (nand_io_oe && !reg_ready));

    a_r12_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ready |-> !nand_io_oe);

    a_r7_re_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> (!reg_ready && !nand_io_oe && nand_we_n));

    a_r13_ce_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_ready && $past(!reg_ready)) |-> $stable(nand_ce_n));
endmodule

bind nandbus_bridge nbb_checker u_nbb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_ready   (reg_ready),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_io_out (nand_io_out),
    .nand_io_oe  (nand_io_oe)
);

// File: tb/tb_nandbus_bridge.sv
module tb_nandbus_bridge;
    localparam int SU = 2;
    localparam int PU = 3;
    localparam int HO = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        reg_ready;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in;
    logic        nand_rb_n = 1'b1;
    logic [7:0]  dev_ptr = 8'h00;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    int m_busy, m_su, m_pu, m_ho, m_re;
    logic m_cle, m_ale, m_oe_bad, m_oe_any, m_lat_bad, m_ce_bad;
    logic [7:0] m_io;

    always #10 clk = ~clk;

    function automatic logic [7:0] dev_byte(input logic [7:0] p);
        return 8'(p * 8'd37 + 8'd11);
    endfunction

    assign nand_io_in = dev_byte(dev_ptr);
    always @(posedge nand_re_n) if (rst_n) dev_ptr <= dev_ptr + 8'd1;

    nandbus_bridge #(
        .SETUP_CLKS  (SU),
        .PULSE_CLKS  (PU),
        .HOLD_CLKS   (HO),
        .SYNC_STAGES (2)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .reg_ready (reg_ready),
        .nand_ce_n (nand_ce_n), .nand_cle (nand_cle), .nand_ale (nand_ale),
        .nand_we_n (nand_we_n), .nand_re_n (nand_re_n),
        .nand_io_out (nand_io_out), .nand_io_oe (nand_io_oe),
        .nand_io_in (nand_io_in), .nand_rb_n (nand_rb_n)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Sample from the negedge after a strobe until reg_ready returns.
    task automatic observe();
        bit first;
        first = 1'b1;
        m_busy = 0; m_su = 0; m_pu = 0; m_ho = 0; m_re = 0;
        m_cle = 0; m_ale = 0; m_io = 0;
        m_oe_bad = 0; m_oe_any = 0; m_lat_bad = 0; m_ce_bad = 0;
        for (int i = 0; i < 64 && !reg_ready; i++) begin
            logic ce_first;
            m_busy++;
            if (!nand_we_n) m_pu++;
            else if (m_pu == 0) m_su++;
            else m_ho++;
            if (!nand_re_n) m_re++;
            if (nand_io_oe) m_oe_any = 1'b1;
            else m_oe_bad = 1'b1;
            if (first) begin
                m_cle = nand_cle; m_ale = nand_ale; m_io = nand_io_out;
                first = 1'b0;
            end else if (m_cle !== nand_cle || m_ale !== nand_ale || m_io !== nand_io_out) begin
                m_lat_bad = 1'b1;
            end
            ce_first = nand_ce_n;
            @(negedge clk);
            if (!reg_ready && nand_ce_n !== ce_first) m_ce_bad = 1'b1;
        end
    endtask

    task automatic do_wr(input logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
        observe();
    endtask

    task automatic do_rd();
        @(negedge clk);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        observe();
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        logic [7:0] base;
        logic       ce_before;
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A; pats[3] = 8'hA5;

        repeat (3) @(negedge clk);
        chk("R1", "ce_n", 32'(nand_ce_n), 32'd1);
        chk("R1", "we_n", 32'(nand_we_n), 32'd1);
        chk("R1", "re_n", 32'(nand_re_n), 32'd1);
        chk("R1", "cle/ale/oe", {29'd0, nand_cle, nand_ale, nand_io_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready", 32'(reg_ready), 32'd1);
        do_rd();
        chk("R1", "no stream after reset re pulses", 32'(m_re), 32'd0);

        // Sweep: every opcode, several bytes, both enable values.
        for (int op = 0; op < 8; op++) begin
            for (int p = 0; p < 4; p++) begin
                for (int ce = 0; ce < 2; ce++) begin
                    logic [31:0] w;
                    w = {ce[0], op[2:0], 4'hC, pats[p] ^ 8'(op), 16'hBEEF};
                    ce_before = nand_ce_n;
                    do_wr(w);
                    if (op == 0 || op == 1 || op == 3) begin
                        chk("R5", "setup clocks", 32'(m_su), 32'(SU));
                        chk("R5", "pulse clocks", 32'(m_pu), 32'(PU));
                        chk("R5", "hold clocks", 32'(m_ho), 32'(HO));
                        chk("R5", "latch steady", 32'(m_lat_bad), 32'd0);
                        chk("R12", "oe through cycle", 32'(m_oe_bad), 32'd0);
                        chk(op == 0 ? "R2" : (op == 1 ? "R3" : "R4"), "cle", 32'(m_cle), 32'(op == 0));
                        chk(op == 0 ? "R2" : (op == 1 ? "R3" : "R4"), "ale", 32'(m_ale), 32'(op == 1));
                        chk(op == 0 ? "R2" : (op == 1 ? "R3" : "R4"), "io byte", 32'(m_io), 32'(pats[p] ^ 8'(op)));
                        chk("R6", "ce steady in cycle", 32'(m_ce_bad), 32'd0);
                        chk("R6", "ce_n after", 32'(nand_ce_n), 32'(ce == 0));
                        chk("R12", "oe idle", 32'(nand_io_oe), 32'd0);
                        do_rd();
                        chk("R9", "no re pulse", 32'(m_re), 32'd0);
                        chk("R9", "ready held", 32'(m_busy), 32'd0);
                        chk("R9", "status word", reg_rdata, 32'd0);
                    end else if (op == 2) begin
                        chk("R7", "no bus cycle", 32'(m_busy), 32'd0);
                        chk("R6", "ce_n stream", 32'(nand_ce_n), 32'(ce == 0));
                        base = dev_ptr;
                        do_rd();
                        chk("R7", "re low clocks", 32'(m_re), 32'(PU));
                        chk("R7", "read busy clocks", 32'(m_busy), 32'(PU + HO));
                        chk("R12", "no drive on read", 32'(m_oe_any), 32'd0);
                        chk("R7", "byte", reg_rdata, {8'h0, dev_byte(base), 16'h0});
                    end else begin
                        chk("R11", "no bus cycle", 32'(m_busy), 32'd0);
                        chk("R11", "ce_n unchanged", 32'(nand_ce_n), 32'(ce_before));
                    end
                end
            end
        end

        // Streaming: six reads give six successive bytes (three 16-bit words).
        do_wr(32'hA000_0000);
        base = dev_ptr;
        for (int k = 0; k < 6; k++) begin
            do_rd();
            chk("R7", "stream byte", reg_rdata, {8'h0, dev_byte(8'(base + 8'(k))), 16'h0});
        end
        chk("R6", "ce_n stream", 32'(nand_ce_n), 32'd0);

        // An ignored opcode still ends streaming.
        do_wr(32'hD000_0000);
        chk("R11", "ce_n kept", 32'(nand_ce_n), 32'd0);
        do_rd();
        chk("R10", "no re after op5", 32'(m_re), 32'd0);

        // Busy visible both in plain and streaming reads.
        nand_rb_n = 1'b0;
        repeat (4) @(negedge clk);
        do_rd();
        chk("R8", "busy status", reg_rdata, 32'h0000_8000);
        do_wr(32'hA000_0000);
        base = dev_ptr;
        do_rd();
        chk("R8", "busy in stream", reg_rdata, {8'h0, dev_byte(base), 16'h8000});
        nand_rb_n = 1'b1;
        repeat (4) @(negedge clk);
        do_rd();
        chk("R8", "ready in stream", reg_rdata, {8'h0, dev_byte(8'(base + 8'd1)), 16'h0});

        // Strobes during a cycle are ignored.
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'h80A5_0000;
        @(negedge clk);
        reg_wdata = 32'hB03C_0000;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        m_pu = 0; m_busy = 0; m_io = nand_io_out; m_cle = nand_cle;
        for (int i = 0; i < 16; i++) begin
            if (!nand_we_n) m_pu++;
            if (!reg_ready) m_busy++;
            @(negedge clk);
        end
        chk("R13", "single pulse", 32'(m_pu), 32'(PU));
        chk("R13", "busy span", 32'(m_busy), 32'(SU + PU + HO - 1));
        chk("R13", "byte kept", 32'(m_io), 32'hA5);
        chk("R13", "cle kept", 32'(m_cle), 32'd1);
        chk("R13", "re untouched", 32'(nand_re_n), 32'd1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule